// File: doc/BRIEF.md
# MSI Pending-Vector Aggregator

This block terminates inbound message-signalled interrupt writes arriving from a PCIe root port and turns each one into a single pending bit. The write address chooses one of 16 groups and one of 8 32-bit pending registers within that group. The low five bits of the write data choose the bit. The unit therefore holds 4096 vectors.

Each group drives one level-high interrupt line. Software services a group by reading that group's summary word, which shows which of its 8 pending registers are nonzero. It then reads those registers. A read of a pending register returns its bits and clears them in the same step, so no separate acknowledge write exists. A read of a summary word changes nothing.

Read data is registered and is returned one cycle after the request. Malformed inbound writes are discarded and flagged with a one-cycle error pulse.

Top module: `msi_aggregator`

## Requirements
- R1: A synchronous active-high `rst` clears every pending bit. In the cycle after any clock edge with `rst` high, `irq`, `wr_err` and `rd_data_valid` are all zero.
- R2: An accepted write has `wr_addr[23]`=0 and `wr_addr[15:0]`=0. It sets bit `wr_data[4:0]` of pending register (group `wr_addr[22:19]`, slot `wr_addr[18:16]`). The change is visible on `irq` in the cycle after the write.
- R3: A read at `(group<<19)|(slot<<16)` returns that pending register on `rd_data` with `rd_data_valid` high in the next cycle. The returned bits are cleared.
- R4: A read at `0x800000|(group<<16)` returns a summary word. Bit k is 1 while slot k of that group is nonzero, and bits 31:8 are zero. This read has no effect on any state.
- R5: `irq[g]` is high exactly while at least one pending register of group g is nonzero. Other groups are unaffected.
- R6: A write and a clearing read may target the same register in the same cycle. The read returns the old contents, and the newly written bit stays pending.
- R7: A write with `wr_addr[23]`=1, or with `wr_addr[15:0]` nonzero, or with any of `wr_data[31:5]` set, is dropped. `wr_err` is then high for exactly the following cycle.
- R8: A read at any other address returns zero with `rd_data_valid` high, and has no side effect.
- R9: Software vector v shows up as group v mod 16, bit (v/16) mod 32, slot v/512.
- R10: Writes accumulate within a register, and writing a bit that is already set leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Inbound message write strobe |
| wr_addr | input | 24 | Write offset within the unit |
| wr_data | input | 32 | Write payload; bits 4:0 select the bit |
| wr_err | output | 1 | One-cycle pulse for a dropped write |
| rd_valid | input | 1 | Read request strobe |
| rd_addr | input | 24 | Read offset |
| rd_data | output | 32 | Read result, one cycle after request |
| rd_data_valid | output | 1 | Marks the cycle carrying `rd_data` |
| irq | output | 16 | Level-high interrupt per group |

## Verification
A table of software vector numbers is walked in a loop. It includes the lowest and highest vectors, vectors at group, bit and slot boundaries, and vectors in between. Each vector is encoded with the R9 mapping and written. The test then checks that exactly one interrupt line rises, that the summary word names exactly one slot, and that the pending read returns exactly one bit and leaves the line low. Together these checks separate a wrong group field from a wrong slot field or a wrong bit field.

Directed patterns cover the remaining cases:
- accumulation of several bits in one register;
- independent groups at both ends of the range;
- a write colliding with a clearing read;
- each of the three kinds of malformed write;
- unmapped reads;
- a reset taken mid-run.

// File: rtl/msi_aggregator.sv
module msi_aggregator #(
  parameter int NGRP  = 16,
  parameter int NIDX  = 8,
  parameter int VW    = 32,
  parameter int SHIFT = 16,
  localparam int GW = $clog2(NGRP),
  localparam int IW = $clog2(NIDX),
  localparam int AW = SHIFT + IW + GW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [VW-1:0] wr_data,
  output logic          wr_err,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  output logic [VW-1:0] rd_data,
  output logic          rd_data_valid,
  output logic [NGRP-1:0] irq
);

  localparam int BW    = $clog2(VW);
  localparam int SW    = IW + GW;
  localparam int NSLOT = NGRP * NIDX;

  logic [SW-1:0] wr_slot, rd_slot;
  logic [GW-1:0] wr_grp, rd_sum_grp;
  logic          wr_good, wr_bad, rd_idx_hit, rd_sum_hit;
  logic [VW-1:0] set_mask;
  logic [NSLOT-1:0] nz;
  logic [VW-1:0] pend [NSLOT];

  assign wr_slot    = wr_addr[AW-2:SHIFT];
  assign wr_grp     = wr_addr[AW-2 -: GW];
  assign rd_slot    = rd_addr[AW-2:SHIFT];
  assign rd_sum_grp = rd_addr[SHIFT+GW-1:SHIFT];

  assign wr_good = wr_valid && !wr_addr[AW-1] && (wr_addr[SHIFT-1:0] == '0)
                   && (wr_data[VW-1:BW] == '0);
  assign wr_bad  = wr_valid && !wr_good;

  assign rd_idx_hit = rd_valid && !rd_addr[AW-1] && (rd_addr[SHIFT-1:0] == '0);
  assign rd_sum_hit = rd_valid && rd_addr[AW-1] && (rd_addr[AW-2:SHIFT+GW] == '0)
                      && (rd_addr[SHIFT-1:0] == '0);

  assign set_mask = {{(VW-1){1'b0}}, 1'b1} << wr_data[BW-1:0];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic hit_w, hit_r;
    assign hit_w = wr_good && (wr_slot == SW'(s));
    assign hit_r = rd_idx_hit && (rd_slot == SW'(s));
    always_ff @(posedge clk) begin
      if (rst) pend[s] <= '0;
      else     pend[s] <= (hit_r ? '0 : pend[s]) | (hit_w ? set_mask : '0);
    end
    assign nz[s] = |pend[s];
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_irq
    assign irq[g] = |nz[g*NIDX +: NIDX];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_err        <= 1'b0;
      rd_data_valid <= 1'b0;
      rd_data       <= '0;
    end else begin
      wr_err        <= wr_bad;
      rd_data_valid <= rd_valid;
      if (rd_idx_hit)      rd_data <= pend[rd_slot];
      else if (rd_sum_hit) rd_data <= {{(VW-NIDX){1'b0}}, nz[rd_sum_grp*NIDX +: NIDX]};
      else                 rd_data <= '0;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (irq == '0 && !wr_err && !rd_data_valid));

  a_r2_write_raises: assert property (@(posedge clk) disable iff (rst)
    wr_good |=> irq[$past(wr_grp)]);

  a_r3_read_latency: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> rd_data_valid);

  a_r4_summary_passive: assert property (@(posedge clk) disable iff (rst)
    (rd_sum_hit && !wr_valid) |=> $stable(irq));

  a_r6_new_bit_kept: assert property (@(posedge clk) disable iff (rst)
    (wr_good && rd_idx_hit && rd_slot == wr_slot) |=> irq[$past(wr_grp)]);

  a_r7_bad_dropped: assert property (@(posedge clk) disable iff (rst)
    (wr_bad && !rd_valid) |=> (wr_err && $stable(irq)));

  a_r7_err_origin: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> $past(wr_valid));

endmodule

// File: tb/msi_aggregator_bench.sv
module msi_aggregator_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  localparam int unsigned VEC [NV] = '{0, 1, 15, 16, 511, 512, 527, 1234, 2049, 3583, 4080, 4095};

  logic        clk = 0, rst = 1;
  logic        wr_valid = 0, rd_valid = 0;
  logic [23:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic        wr_err, rd_data_valid;
  logic [31:0] rd_data;
  logic [15:0] irq;
  int checks = 0, failures = 0;

  msi_aggregator u_msi_aggregator (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_err(wr_err), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_data_valid(rd_data_valid), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] idx_addr(input int g, input int i);
    return 24'((g << 19) | (i << 16));
  endfunction

  function automatic logic [23:0] sum_addr(input int g);
    return 24'(32'h800000 | (g << 16));
  endfunction

  task automatic wr(input logic [23:0] a, input logic [31:0] d);
    @(negedge clk); wr_valid = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic rd(input logic [23:0] a, output logic [31:0] d);
    @(negedge clk); rd_valid = 1; rd_addr = a;
    @(negedge clk); rd_valid = 0; d = rd_data;
    chk("R3 rd_data_valid", 32'(rd_data_valid), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    repeat (3) @(negedge clk);
    chk("R1 irq after reset", 32'(irq), 0);
    chk("R1 wr_err after reset", 32'(wr_err), 0);
    chk("R1 rd_data_valid after reset", 32'(rd_data_valid), 0);
    rst = 0;

    for (int k = 0; k < NV; k++) begin
      int v, g, b, i;
      v = int'(VEC[k]); g = v % 16; b = (v / 16) % 32; i = v / 512;
      wr(idx_addr(g, i), 32'(b));
      chk("R7 no error on good write", 32'(wr_err), 0);
      chk("R9 R5 irq for vector", 32'(irq), 32'(1) << g);
      rd(sum_addr(g), d);
      chk("R4 summary slot", d, 32'(1) << i);
      rd(idx_addr(g, i), d);
      chk("R2 R9 pending bit", d, 32'(1) << b);
      chk("R3 irq cleared by read", 32'(irq), 0);
      rd(idx_addr(g, i), d);
      chk("R3 register empty after read", d, 0);
    end

    wr(idx_addr(5, 2), 3); wr(idx_addr(5, 2), 7); wr(idx_addr(5, 2), 3);
    rd(idx_addr(5, 2), d);
    chk("R10 accumulate", d, 32'h88);

    wr(idx_addr(0, 0), 0); wr(idx_addr(15, 7), 31);
    chk("R5 two groups", 32'(irq), 32'h8001);
    rd(sum_addr(15), d); rd(sum_addr(15), d2);
    chk("R4 summary repeatable", d2, d);
    chk("R4 summary value", d, 32'h80);
    chk("R4 irq untouched by summary", 32'(irq), 32'h8001);
    rd(idx_addr(0, 0), d);
    chk("R5 only group0 cleared", 32'(irq), 32'h8000);
    rd(24'h900000, d);
    chk("R8 unmapped read zero", d, 0);
    rd(24'h810004, d);
    chk("R8 misaligned read zero", d, 0);
    chk("R8 no side effect", 32'(irq), 32'h8000);
    rd(idx_addr(15, 7), d);
    chk("R2 top slot top bit", d, 32'h80000000);

    wr(idx_addr(2, 0), 1);
    @(negedge clk); rd_valid = 1; rd_addr = idx_addr(2, 0);
    wr_valid = 1; wr_addr = idx_addr(2, 0); wr_data = 9;
    @(negedge clk); rd_valid = 0; wr_valid = 0;
    chk("R6 read returns old bits", rd_data, 32'h2);
    chk("R6 irq still high", 32'(irq), 32'h4);
    rd(idx_addr(2, 0), d);
    chk("R6 new bit survived", d, 32'h200);

    wr(24'h800000, 0);
    chk("R7 err on high window", 32'(wr_err), 1);
    chk("R7 dropped high window", 32'(irq), 0);
    @(negedge clk);
    chk("R7 err single cycle", 32'(wr_err), 0);
    wr(24'h010004, 0);
    chk("R7 err on low offset bits", 32'(wr_err), 1);
    chk("R7 dropped misaligned", 32'(irq), 0);
    wr(idx_addr(3, 1), 32'h20);
    chk("R7 err on data bits", 32'(wr_err), 1);
    chk("R7 dropped bad data", 32'(irq), 0);
    rd(idx_addr(3, 1), d);
    chk("R7 nothing stored", d, 0);

    wr(idx_addr(6, 4), 12); wr(idx_addr(9, 0), 1);
    @(negedge clk); rst = 1;
    @(negedge clk);
    chk("R1 irq after mid reset", 32'(irq), 0);
    rst = 0;
    rd(idx_addr(6, 4), d);
    chk("R1 pending cleared", d, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule